// File: doc/BRIEF.md
# Fixed-Point Exception Status Register

This block holds the integer exception and status state of a processor core in a single 32-bit register. It has a sticky summary-overflow flag, an overflow flag, a carry flag and a 7-bit transfer-length field. On each cycle the integer execution stage may send one update request. The request carries an operation-type code, an overflow-enable qualifier, the two adder carry-outs used to detect signed overflow, per-width "result not representable" indications from the multiply/divide unit, and a carry result. The register decides which flags that request changes.

Two other paths reach the register. A full write (move-to-special-register) loads a whole new value, with no sticky behaviour applied. A move-to-condition-field request returns the four most significant bits on a 4-bit output and clears them at the next clock edge. The register value is always visible on a registered output.

Top module: `fxstat_reg`

## Requirements
- R1: A synchronous active-high reset clears the entire register to zero.
- R2: The summary-overflow flag sits in bit 31, the overflow flag in bit 30, the carry flag in bit 29 and the transfer length in bits 6:0. Bits 28:7 always read as zero, and a write to them has no effect.
- R3: For op codes 1 (add/subtract-from/negate) and 2 (carrying add) with the overflow-enable qualifier set, the overflow flag becomes the XOR of the carry out of the msb and the carry out of the msb+1 position.
- R4: With the overflow-enable qualifier set, op code 3 (word multiply-low/divide) loads the overflow flag from the 32-bit "not representable" input, and op code 4 (doubleword form) loads it from the 64-bit input.
- R5: When a request other than a full write sets the overflow flag, the summary-overflow flag is also set. The summary-overflow flag is not cleared when a later operation clears the overflow flag.
- R6: A request with the overflow-enable qualifier clear, or with op code 0, 5, 6 or 7, leaves both the overflow flag and the summary-overflow flag unchanged.
- R7: A full write loads its value at the next edge with the reserved bits masked. For example, summary-overflow 0 with overflow 1 is loaded as given. A full write takes priority over every other request in the same cycle.
- R8: The 4-bit field output always equals bits 31:28. A move-to-condition-field request without a full write clears bits 31:28 at the next edge, and an update request in that same cycle is ignored.
- R9: The carry flag is loaded from the carry input only for op codes 2 and 5. The transfer length changes only on a full write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_code | input | 3 | Operation type of this cycle's update request |
| ovf_en | input | 1 | Overflow-enable qualifier |
| cout_msb | input | 1 | Adder carry out of the msb |
| cout_msb1 | input | 1 | Adder carry out of the msb+1 position |
| unrep_w | input | 1 | Multiply/divide result not representable in 32 bits |
| unrep_d | input | 1 | Multiply/divide result not representable in 64 bits |
| carry_in | input | 1 | Carry result of the operation |
| wr_en | input | 1 | Full register write strobe |
| wr_data | input | 32 | Full register write value |
| mcf_req | input | 1 | Move-to-condition-field request |
| mcf_field | output | 4 | Current bits 31:28 |
| reg_q | output | 32 | Register value |

## Verification
Every request type changes the register at the clock edge that samples it, so each result on reg_q is due exactly one cycle after the stimulus. mcf_field is due in the same cycle because it is taken straight from the register. The bench drives a request on a falling edge and updates its behavioural model for the coming rising edge. On the next falling edge it compares reg_q and mcf_field with the model, so every comparison lands one edge after its stimulus. Directed cases cover the write/update and field/update collisions and the sticky flag. A long stretch of random requests then exercises the same one-cycle rule.

// File: rtl/fxstat_pkg.sv
package fxstat_pkg;
  typedef enum logic [2:0] {
    FX_NOP      = 3'd0,
    FX_ADD      = 3'd1,
    FX_ADD_CY   = 3'd2,
    FX_MULDIV_W = 3'd3,
    FX_MULDIV_D = 3'd4,
    FX_CY_ONLY  = 3'd5,
    FX_RSV6     = 3'd6,
    FX_RSV7     = 3'd7
  } fx_op_e;

  typedef struct packed {
    logic ovf_upd;
    logic ovf_val;
    logic ca_upd;
    logic ca_val;
  } fx_upd_t;
endpackage

// File: rtl/fxstat_eval.sv
module fxstat_eval
  import fxstat_pkg::*;
(
  input  logic [2:0] op_code,
  input  logic       ovf_en,
  input  logic       cout_msb,
  input  logic       cout_msb1,
  input  logic       unrep_w,
  input  logic       unrep_d,
  input  logic       carry_in,
  output fx_upd_t    upd
);
  fx_op_e op;
  assign op = fx_op_e'(op_code);

  always_comb begin
    upd = '0;
    case (op)
      FX_ADD: begin
        upd.ovf_upd = ovf_en;
        upd.ovf_val = cout_msb ^ cout_msb1;
      end
      FX_ADD_CY: begin
        upd.ovf_upd = ovf_en;
        upd.ovf_val = cout_msb ^ cout_msb1;
        upd.ca_upd  = 1'b1;
        upd.ca_val  = carry_in;
      end
      FX_MULDIV_W: begin
        upd.ovf_upd = ovf_en;
        upd.ovf_val = unrep_w;
      end
      FX_MULDIV_D: begin
        upd.ovf_upd = ovf_en;
        upd.ovf_val = unrep_d;
      end
      FX_CY_ONLY: begin
        upd.ca_upd = 1'b1;
        upd.ca_val = carry_in;
      end
      default: upd = '0;
    endcase
  end
endmodule

// File: rtl/fxstat_core.sv
module fxstat_core
  import fxstat_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 7,
  parameter int FIELD_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  fx_upd_t           upd,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              mcf_req,
  output logic [DATA_W-1:0] q
);
  localparam int SUM_B = DATA_W - 1;
  localparam int OVF_B = DATA_W - 2;
  localparam int CA_B  = DATA_W - 3;
  localparam int RSV_W = DATA_W - 3 - CNT_W;
  localparam logic [DATA_W-1:0] WR_MASK =
    {{3{1'b1}}, {RSV_W{1'b0}}, {CNT_W{1'b1}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (wr_en) begin
      q <= wr_data & WR_MASK;
    end else if (mcf_req) begin
      q[DATA_W-1 -: FIELD_W] <= '0;
    end else begin
      if (upd.ovf_upd) begin
        q[OVF_B] <= upd.ovf_val;
        if (upd.ovf_val) q[SUM_B] <= 1'b1;
      end
      if (upd.ca_upd) q[CA_B] <= upd.ca_val;
    end
  end
endmodule

// File: rtl/fxstat_reg.sv
module fxstat_reg
  import fxstat_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 7,
  parameter int FIELD_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        op_code,
  input  logic              ovf_en,
  input  logic              cout_msb,
  input  logic              cout_msb1,
  input  logic              unrep_w,
  input  logic              unrep_d,
  input  logic              carry_in,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              mcf_req,
  output logic [FIELD_W-1:0] mcf_field,
  output logic [DATA_W-1:0] reg_q
);
  fx_upd_t upd;

  fxstat_eval u_eval (
    .op_code   (op_code),
    .ovf_en    (ovf_en),
    .cout_msb  (cout_msb),
    .cout_msb1 (cout_msb1),
    .unrep_w   (unrep_w),
    .unrep_d   (unrep_d),
    .carry_in  (carry_in),
    .upd       (upd)
  );

  fxstat_core #(
    .DATA_W  (DATA_W),
    .CNT_W   (CNT_W),
    .FIELD_W (FIELD_W)
  ) u_core (
    .clk     (clk),
    .rst     (rst),
    .upd     (upd),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .mcf_req (mcf_req),
    .q       (reg_q)
  );

  assign mcf_field = reg_q[DATA_W-1 -: FIELD_W];
endmodule

// File: rtl/fxstat_chk.sv
module fxstat_chk #(
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 7,
  parameter int FIELD_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        op_code,
  input logic              ovf_en,
  input logic              cout_msb,
  input logic              cout_msb1,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic              mcf_req,
  input logic [DATA_W-1:0] reg_q
);
  localparam int RSV_W = DATA_W - 3 - CNT_W;
  localparam logic [DATA_W-1:0] KEEP =
    {{3{1'b1}}, {RSV_W{1'b0}}, {CNT_W{1'b1}}};

  logic plain;
  assign plain = !wr_en && !mcf_req;

  p_reset_zero_r1: assert property (@(posedge clk)
    rst |=> reg_q == '0);

  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (rst)
    reg_q[DATA_W-4:CNT_W] == '0);

  p_add_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    plain && ovf_en && op_code == 3'd1 && (cout_msb != cout_msb1)
    |=> reg_q[DATA_W-1] && reg_q[DATA_W-2]);

  p_sticky_sum_r5: assert property (@(posedge clk) disable iff (rst)
    plain && reg_q[DATA_W-1] |=> reg_q[DATA_W-1]);

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
    plain && !ovf_en |=> $stable(reg_q[DATA_W-1 -: 2]));

  p_write_load_r7: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> reg_q == ($past(wr_data) & KEEP));

  p_field_clear_r8: assert property (@(posedge clk) disable iff (rst)
    mcf_req && !wr_en |=> reg_q[DATA_W-1 -: FIELD_W] == '0);

  p_count_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(reg_q[CNT_W-1:0]));
endmodule

bind fxstat_reg fxstat_chk #(
  .DATA_W  (DATA_W),
  .CNT_W   (CNT_W),
  .FIELD_W (FIELD_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .op_code   (op_code),
  .ovf_en    (ovf_en),
  .cout_msb  (cout_msb),
  .cout_msb1 (cout_msb1),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .mcf_req   (mcf_req),
  .reg_q     (reg_q)
);

// File: tb/tb_fxstat_reg.sv
`timescale 1ns/1ps
module tb_fxstat_reg;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  op_code = '0;
  logic        ovf_en = 0, cout_msb = 0, cout_msb1 = 0;
  logic        unrep_w = 0, unrep_d = 0, carry_in = 0;
  logic        wr_en = 0, mcf_req = 0;
  logic [31:0] wr_data = '0;
  logic [3:0]  mcf_field;
  logic [31:0] reg_q;

  int checks = 0;
  int failures = 0;
  logic [31:0] model = '0;

  always #10 clk = ~clk;

  fxstat_reg dut (
    .clk(clk), .rst(rst), .op_code(op_code), .ovf_en(ovf_en),
    .cout_msb(cout_msb), .cout_msb1(cout_msb1), .unrep_w(unrep_w),
    .unrep_d(unrep_d), .carry_in(carry_in), .wr_en(wr_en),
    .wr_data(wr_data), .mcf_req(mcf_req), .mcf_field(mcf_field),
    .reg_q(reg_q)
  );

  function automatic logic [31:0] ref_next(
    input logic [31:0] cur, input int op, input bit oe, c1, c2, uw, ud,
    cin, we, input logic [31:0] wd, input bit mr);
    logic [31:0] n;
    bit has_ov, ovv;
    n = cur;
    has_ov = 0;
    ovv = 0;
    if (we) return wd & 32'hE000_007F;
    if (mr) begin
      n[31:28] = 4'h0;
      return n;
    end
    if (oe && (op == 1 || op == 2)) begin has_ov = 1; ovv = (c1 != c2); end
    if (oe && op == 3) begin has_ov = 1; ovv = uw; end
    if (oe && op == 4) begin has_ov = 1; ovv = ud; end
    if (has_ov) begin
      n[30] = ovv;
      if (ovv) n[31] = 1'b1;
    end
    if (op == 2 || op == 5) n[29] = cin;
    return n;
  endfunction

  task automatic check(input string req, input logic [31:0] act, exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input string req, input int op, input bit oe, c1, c2,
                      uw, ud, cin, we, input logic [31:0] wd, input bit mr);
    op_code = op[2:0]; ovf_en = oe; cout_msb = c1; cout_msb1 = c2;
    unrep_w = uw; unrep_d = ud; carry_in = cin; wr_en = we;
    wr_data = wd; mcf_req = mr;
    model = ref_next(model, op, oe, c1, c2, uw, ud, cin, we, wd, mr);
    @(posedge clk);
    @(negedge clk);
    check(req, reg_q, model);
    check({req, " field"}, {28'h0, mcf_field}, {28'h0, model[31:28]});
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset", reg_q, 32'h0);
    // R7: SO clear with OV set loads verbatim
    step("R7 write", 0, 0, 0, 0, 0, 0, 0, 1, 32'h4000_0000, 0);
    // R2: reserved bits masked
    step("R2 mask", 0, 0, 0, 0, 0, 0, 0, 1, 32'hFFFF_FFFF, 0);
    // R8: field clear
    step("R8 clear", 0, 0, 0, 0, 0, 0, 0, 0, 32'h0, 1);
    // R3 and R5: add overflow sets both
    step("R3 add ovf", 1, 1, 1, 0, 0, 0, 0, 0, 32'h0, 0);
    step("R5 sticky", 1, 1, 1, 1, 0, 0, 0, 0, 32'h0, 0);
    // R6: disabled overflow and compare
    step("R6 oe off", 1, 0, 0, 1, 0, 0, 0, 0, 32'h0, 0);
    step("R6 cmp", 0, 1, 0, 1, 1, 1, 1, 0, 32'h0, 0);
    step("R6 op6", 6, 1, 0, 1, 1, 1, 1, 0, 32'h0, 0);
    // R4: width selection
    step("R4 word", 3, 1, 0, 0, 1, 0, 0, 0, 32'h0, 0);
    step("R4 dword", 4, 1, 0, 0, 1, 0, 0, 0, 32'h0, 0);
    step("R4 dword set", 4, 1, 0, 0, 0, 1, 0, 0, 32'h0, 0);
    // R9: carry only on ops 2 and 5
    step("R9 addc", 2, 0, 0, 0, 0, 0, 1, 0, 32'h0, 0);
    step("R9 no ca", 3, 0, 0, 0, 0, 0, 0, 0, 32'h0, 0);
    step("R9 cy only", 5, 1, 1, 0, 0, 0, 0, 0, 32'h0, 0);
    // R7: write wins over update
    step("R7 priority", 1, 1, 1, 0, 0, 0, 1, 1, 32'h0000_0055, 0);
    // R8: update ignored during field move
    step("R8 collide", 2, 1, 1, 0, 0, 0, 1, 0, 32'h0, 1);
    for (int i = 0; i < 3000; i++) begin
      step("random", $urandom_range(0, 7), $urandom_range(0, 1) == 1,
           $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
           $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
           $urandom_range(0, 1) == 1, $urandom_range(0, 9) == 0,
           $urandom, $urandom_range(0, 9) == 0);
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule